// File: doc/BRIEF.md
# Keyed-feed watchdog timer

This block watches for stalled software. While enabled, a counter steps up once per clock. Software keeps it alive by "feeding" it with an ordered pair of byte writes to a write-only feed register. Any other value aborts a feed that has only been half entered.

Two timeouts are programmed separately as 4-bit power-of-two codes. The shorter one raises a sticky interrupt flag, which drives an interrupt line when the interrupt is enabled. The longer one emits a single-cycle system reset request and records it in a reset flag. The reset flag survives that system reset and is cleared only by the block's own reset or by software.

The block is reached through a plain register bus: an address, a write strobe, 32-bit write data, and registered read data. A control/status word sits at offset 0x00 and the feed register at offset 0x04. The counter width and the largest timeout exponent are parameters, so the timeouts can be scaled down.

Top module: `wdog_keyed`

## Requirements
- R1: After reset, the control/status word reads 0x00000000, and both `irq_o` and `sys_rst_req_o` are low.
- R2: The control/status word has this layout:
  - bits [3:0]: interrupt period code
  - bits [7:4]: reset period code
  - bit 8: timer enable
  - bit 9: interrupt pending
  - bit 10: interrupt enable
  - bit 11: reset enable
  - bit 31: reset-occurred flag

  Bits [30:12] read as 0. Read data appears on the clock edge that samples the address, and offset 0x04 reads as 0.
- R3: With the timer and the interrupt enabled, and a code n, the pending flag sets once the count reaches 2^(EXP_MAX-n). `irq_o` is first high after the (2^(EXP_MAX-n)+1)-th rising edge that follows the edge which enabled the timer or completed a feed.
- R4: With the timer and reset enabled, and a reset code m, `sys_rst_req_o` is high for exactly one clock, after the (2^(EXP_MAX-m)+1)-th edge from the start point.
- R5: The reset-occurred flag sets together with the reset request. A write to bit 31 sets or clears it to the written value.
- R6: Writing 1 to bit 9 clears the pending flag, and writing 0 leaves it unchanged. A timeout that is detected in the same cycle wins over the clear.
- R7: `irq_o` equals the pending flag ANDed with the interrupt enable. Clearing the enable hides a pending flag, and setting it again shows the flag.
- R8: A write of 0xA5 to the low byte of offset 0x04, immediately followed by a write of 0x5A to the same place, restarts the count from zero.
- R9: A feed write with any other value after 0xA5 aborts the sequence. A lone 0x5A does not restart the count.
- R10: A 0xA5 written while the sequence is armed re-arms it, and writes to offset 0x00 between the two key values do not disturb the sequence.
- R11: While the timer is disabled, the count is held at zero and no event occurs. Enabling it starts the count from zero.
- R12: With the interrupt enable clear, the pending flag never sets. With the reset enable clear, no reset request is made and the reset flag does not set.
- R13: The timeout for code c is 2^(EXP_MAX-c) cycles, with EXP_MAX ≥ 15 and CNT_W > EXP_MAX. The count saturates at its maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the block |
| bus_addr_i | input | ADDR_W | Register byte offset |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt: pending flag AND interrupt enable |
| sys_rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with EXP_MAX = 18 and CNT_W = 19, so the codes 12, 13 and 15 give timeouts of 64, 32 and 8 cycles. This brings exact timeout edges, feed restarts, aborted keys and reset pulses within a few hundred cycles. Because each expected interrupt or reset edge is queued with the precise cycle it must occur in, a feed that is accepted when it should not be, or missed when it should be, shows up as an event in the wrong cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // register offsets
  localparam int OFF_CTRL = 0;
  localparam int OFF_FEED = 4;

  // feed key, entered in this order
  localparam logic [7:0] KEY_FIRST  = 8'hA5;
  localparam logic [7:0] KEY_SECOND = 8'h5A;

  // bit positions of the control/status word
  localparam int POS_IFLAG = 9;
  localparam int POS_RFLAG = 31;

  typedef struct packed {
    logic       rflag;
    logic       ren;
    logic       ien;
    logic       iflag;
    logic       en;
    logic [3:0] rcode;
    logic [3:0] icode;
  } ctrl_t;

  function automatic logic [31:0] pack_ctrl(ctrl_t c);
    return {c.rflag, 19'b0, c.ren, c.ien, c.iflag, c.en, c.rcode, c.icode};
  endfunction
endpackage

// File: rtl/wdog_limit_dec.sv
module wdog_limit_dec #(
  parameter int CNT_W   = 32,
  parameter int EXP_MAX = 31
) (
  input  logic [3:0]       code_i,
  output logic [CNT_W-1:0] limit_o
);
  localparam int EXP_W = $clog2(EXP_MAX + 1);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [EXP_W-1:0] exp_w;

  always_comb begin
    exp_w   = EXP_W'(EXP_MAX) - EXP_W'(code_i);
    limit_o = ONE << exp_w;
  end
endmodule

// File: rtl/wdog_key_seq.sv
module wdog_key_seq
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_i,
  input  logic [7:0] data_i,
  output logic       feed_o
);
  logic armed_q;

  // a matching second key completes the feed
  assign feed_o = wr_i && armed_q && (data_i == KEY_SECOND);

  // any feed write re-evaluates the arming: only the first key arms
  always_ff @(posedge clk) begin
    if (rst)       armed_q <= 1'b0;
    else if (wr_i) armed_q <= (data_i == KEY_FIRST);
  end

  // R9
  seq_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_i && data_i != KEY_FIRST) |=> !armed_q);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             feed_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en_i || feed_i) cnt_q <= '0;
    else if (cnt_q != CNT_MAX)  cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;

  // R8
  feed_clear_chk: assert property (@(posedge clk) disable iff (rst)
    feed_i |=> cnt_q == '0);

  // R13
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (en_i && !feed_i && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int CNT_W   = 32,
  parameter int EXP_MAX = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_o,
  output logic              sys_rst_req_o
);
  localparam int N_LIM = 2;  // 0: interrupt, 1: reset

  ctrl_t            csr_q;
  logic [31:0]      rdata_q;
  logic             rreq_q;
  logic             sel_ctrl, sel_feed, wr_ctrl, wr_feed, feed;
  logic [CNT_W-1:0] cnt;
  logic [3:0]       code_v [N_LIM];
  logic [CNT_W-1:0] lim_v  [N_LIM];
  logic             int_hit, rst_hit;
  logic             unused_wdata;

  assign sel_ctrl     = (bus_addr_i == ADDR_W'(OFF_CTRL));
  assign sel_feed     = (bus_addr_i == ADDR_W'(OFF_FEED));
  assign wr_ctrl      = bus_wr_i && sel_ctrl;
  assign wr_feed      = bus_wr_i && sel_feed;
  assign unused_wdata = ^bus_wdata_i[30:12];

  wdog_key_seq u_key (
    .clk    (clk),
    .rst    (rst),
    .wr_i   (wr_feed),
    .data_i (bus_wdata_i[7:0]),
    .feed_o (feed)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .en_i   (csr_q.en),
    .feed_i (feed),
    .cnt_o  (cnt)
  );

  assign code_v[0] = csr_q.icode;
  assign code_v[1] = csr_q.rcode;

  for (genvar g = 0; g < N_LIM; g++) begin : g_lim
    wdog_limit_dec #(.CNT_W(CNT_W), .EXP_MAX(EXP_MAX)) u_dec (
      .code_i  (code_v[g]),
      .limit_o (lim_v[g])
    );
  end

  // interrupt is a level compare (sticky flag); reset fires on the exact hit
  assign int_hit = csr_q.en && csr_q.ien && (cnt >= lim_v[0]);
  assign rst_hit = csr_q.en && csr_q.ren && (cnt == lim_v[1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_q   <= '0;
      rdata_q <= '0;
      rreq_q  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        csr_q.icode <= bus_wdata_i[3:0];
        csr_q.rcode <= bus_wdata_i[7:4];
        csr_q.en    <= bus_wdata_i[8];
        csr_q.ien   <= bus_wdata_i[10];
        csr_q.ren   <= bus_wdata_i[11];
        csr_q.rflag <= bus_wdata_i[POS_RFLAG];
        if (bus_wdata_i[POS_IFLAG]) csr_q.iflag <= 1'b0;
      end
      if (int_hit) csr_q.iflag <= 1'b1;
      if (rst_hit) csr_q.rflag <= 1'b1;
      rreq_q  <= rst_hit;
      rdata_q <= sel_ctrl ? pack_ctrl(csr_q) : 32'h0;
    end
  end

  assign bus_rdata_o   = rdata_q;
  assign irq_o         = csr_q.iflag & csr_q.ien;
  assign sys_rst_req_o = rreq_q;

  // R4
  rst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req_o |=> !sys_rst_req_o);

  // R5
  rst_flag_chk: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req_o |-> csr_q.rflag);

  // R12
  masked_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (!csr_q.ien && !csr_q.iflag) |=> !csr_q.iflag);

  // R11
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !csr_q.en |=> !sys_rst_req_o);
endmodule

// File: tb/sim_wdog_keyed.sv
`timescale 1ns/1ps
module sim_wdog_keyed;
  localparam int AW = 8;
  localparam int CW = 19;
  localparam int EM = 18;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          wr = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq, rreq;

  always #2.5 clk = ~clk;

  wdog_keyed #(.ADDR_W(AW), .CNT_W(CW), .EXP_MAX(EM)) u0 (
    .clk(clk), .rst(rst), .bus_addr_i(addr), .bus_wr_i(wr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq), .sys_rst_req_o(rreq)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  typedef struct { int at; string req; } ev_t;
  ev_t q_irq[$], q_rst[$];
  ev_t ev;
  logic [31:0] shadow = '0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(bit rf, bit ren, bit ien, bit ifl, bit en,
                                     logic [3:0] rc, logic [3:0] ic);
    return {rf, 19'b0, ren, ien, ifl, en, rc, ic};
  endfunction

  task automatic bus_write(logic [AW-1:0] a, logic [31:0] d, output int t);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); #1;
    wr = 1'b0; t = cyc;
  endtask

  task automatic ctrl_write(logic [31:0] d, output int t);
    shadow = d & ~(32'h1 << 9);
    bus_write(8'h00, d, t);
  endtask

  task automatic bus_read(logic [AW-1:0] a, output logic [31:0] d);
    addr = a;
    @(posedge clk); #1;
    d = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push_irq(int at, string req);
    ev_t e; e.at = at; e.req = req; q_irq.push_back(e);
  endtask

  task automatic push_rst(int at, string req);
    ev_t e; e.at = at; e.req = req; q_rst.push_back(e);
  endtask

  // stop the timer, then clear the pending flag
  task automatic quiesce();
    int t;
    ctrl_write(shadow & ~(32'h1 << 8), t);
    ctrl_write(shadow | (32'h1 << 9), t);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  // monitor: pops expected events and compares their cycle
  logic irq_d = 1'b0;
  logic rst_follow = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (rst_follow) begin
        check("R4 pulse width", {31'b0, rreq}, 32'h0);
        rst_follow = 1'b0;
      end
      if (irq && !irq_d) begin
        if (q_irq.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R3 unexpected irq actual=%0d expected=none", cyc);
        end else begin
          ev = q_irq.pop_front();
          check(ev.req, cyc, ev.at);
        end
      end
      irq_d = irq;
      if (rreq) begin
        if (q_rst.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R4 unexpected reset request actual=%0d expected=none", cyc);
        end else begin
          ev = q_rst.pop_front();
          check(ev.req, cyc, ev.at);
        end
        rst_follow = 1'b1;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    int t, tf;
    logic [31:0] d;
    idle(4);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    bus_read(8'h00, d);
    check("R1 ctrl", d, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 rreq", {31'b0, rreq}, 32'h0);

    // R2 layout, reserved bits, feed offset
    ctrl_write(32'h7FFF_F000 | mk(0, 1, 1, 0, 0, 4'hA, 4'h3), t);
    bus_read(8'h00, d);
    check("R2 layout", d, 32'h0000_0CA3);
    bus_read(8'h04, d);
    check("R2 feed reads zero", d, 32'h0);

    // R3 R13: code 13 with EXP_MAX 18 gives 32 cycles
    ctrl_write(mk(0, 0, 1, 0, 1, 4'h0, 4'hD), t);
    push_irq(t + 33, "R3 R13 irq timing");
    idle(40);
    bus_read(8'h00, d);
    check("R3 pending", (d >> 9) & 1, 1);

    // R6 / R7
    ctrl_write(mk(0, 0, 1, 0, 0, 4'h0, 4'hD), t);
    check("R7 irq shown", {31'b0, irq}, 32'h1);
    ctrl_write(mk(0, 0, 0, 0, 0, 4'h0, 4'hD), t);
    check("R7 irq masked", {31'b0, irq}, 32'h0);
    bus_read(8'h00, d);
    check("R6 write 0 keeps", (d >> 9) & 1, 1);
    ctrl_write(mk(0, 0, 1, 0, 0, 4'h0, 4'hD), t);
    push_irq(t, "R7 unmask");
    idle(1);
    check("R7 irq unmasked", {31'b0, irq}, 32'h1);
    ctrl_write(mk(0, 0, 1, 1, 0, 4'h0, 4'hD), t);
    check("R6 irq after clear", {31'b0, irq}, 32'h0);
    bus_read(8'h00, d);
    check("R6 write 1 clears", (d >> 9) & 1, 0);

    // R8 feed restarts the count
    ctrl_write(mk(0, 0, 1, 0, 1, 4'h0, 4'hC), t);
    idle(40);
    bus_write(8'h04, 32'hA5, t);
    bus_write(8'h04, 32'h5A, tf);
    push_irq(tf + 65, "R8 feed");
    idle(80);
    quiesce();

    // R9 aborted and lone keys do not feed
    ctrl_write(mk(0, 0, 1, 0, 1, 4'h0, 4'hC), t);
    push_irq(t + 65, "R9 abort");
    idle(10);
    bus_write(8'h04, 32'hA5, tf);
    bus_write(8'h04, 32'h11, tf);
    bus_write(8'h04, 32'h5A, tf);
    bus_write(8'h04, 32'h5A, tf);
    idle(70);
    quiesce();

    // R10 re-arm and intervening control write
    ctrl_write(mk(0, 0, 1, 0, 1, 4'h0, 4'hC), t);
    idle(30);
    bus_write(8'h04, 32'hA5, tf);
    bus_write(8'h04, 32'hA5, tf);
    ctrl_write(shadow, tf);
    bus_write(8'h04, 32'h5A, tf);
    push_irq(tf + 65, "R10 rearm");
    idle(80);
    quiesce();

    // R4 R5 R12: reset code 15 gives 8 cycles; interrupt off
    ctrl_write(mk(0, 1, 0, 0, 1, 4'hF, 4'hF), t);
    push_rst(t + 9, "R4 reset timing");
    idle(20);
    bus_read(8'h00, d);
    check("R5 flag set", (d >> 31) & 1, 1);
    check("R12 no pending with ie off", (d >> 9) & 1, 0);
    ctrl_write(mk(0, 1, 0, 0, 0, 4'hF, 4'hF), t);
    bus_read(8'h00, d);
    check("R5 sw clear", (d >> 31) & 1, 0);
    ctrl_write(mk(1, 1, 0, 0, 0, 4'hF, 4'hF), t);
    bus_read(8'h00, d);
    check("R5 sw set", (d >> 31) & 1, 1);
    ctrl_write(mk(0, 1, 0, 0, 0, 4'hF, 4'hF), t);

    // R12 reset enable off
    ctrl_write(mk(0, 0, 0, 0, 1, 4'hF, 4'hF), t);
    idle(30);
    bus_read(8'h00, d);
    check("R12 no reset flag", (d >> 31) & 1, 0);

    // R11 disabled timer is quiet and restarts from zero
    ctrl_write(mk(0, 1, 1, 0, 0, 4'hF, 4'hF), t);
    idle(40);
    bus_read(8'h00, d);
    check("R11 no pending", (d >> 9) & 1, 0);
    check("R11 no reset flag", (d >> 31) & 1, 0);
    check("R11 irq low", {31'b0, irq}, 32'h0);
    ctrl_write(mk(0, 1, 0, 0, 1, 4'hF, 4'hF), t);
    push_rst(t + 9, "R11 restart from zero");
    idle(20);

    while (q_irq.size() > 0) begin
      ev = q_irq.pop_front();
      n_chk++; n_bad++;
      $display("FAIL %s actual=none expected=%0d", ev.req, ev.at);
    end
    while (q_rst.size() > 0) begin
      ev = q_rst.pop_front();
      n_chk++; n_bad++;
      $display("FAIL %s actual=none expected=%0d", ev.req, ev.at);
    end
    summary();
    $finish;
  end
endmodule